// File: doc/BRIEF.md
# Synthesiser Loop Divider and Phase Detector Core

This block is the digital heart of a frequency synthesiser loop. A reference divider turns the reference clock into a comparison strobe. Its ratio is either 512 or 1024, picked by a control bit. A programmable divider counts pulses from the prescaled local oscillator and emits one strobe every N pulses, where N is a 15-bit ratio. A dual-flip-flop phase/frequency detector compares the two strobes and drives pump-up and pump-down requests. A lock detector watches how wide those requests are and raises a lock flag.

The block also produces the analog-side controls: pump current select, pump disable and drive-amplifier disable. It also drives four open-drain port enables. The block takes its settings as plain register fields from a serial-bus decoder elsewhere on the chip. A test-mode field can force the pump direction and the lock flag, or route internal divider waveforms onto the port pins for measurement.

The block runs in the reference clock domain. The prescaled oscillator arrives as a one-cycle enable `osc_tick` that is synchronous to that clock.

Top module: `synth_loop_core`

## Requirements
- R1: With `test_en`=0, `test_sel[0]`=1 selects a comparison period of 512 clock cycles and `test_sel[0]`=0 selects 1024. The comparison waveform is visible as port bit 2 (P6) in test codes 110/111.
- R2: While `test_en`=1, the reference ratio keeps the value last chosen with `test_en`=0, whatever `test_sel[0]` holds.
- R3: The programmable divider completes one output period for every `div_ratio` pulses of `osc_tick`. Cycles without `osc_tick` do not advance it.
- R4: A new `div_ratio` takes effect only when the current divider period ends. The period in progress keeps the old length.
- R5: `pump_up` is asserted when the divided-oscillator strobe lags the comparison strobe, and `pump_dn` when it leads. The two are never asserted together.
- R6: `lock_flag` rises after 4 consecutive comparison windows whose pump pulse width is at most 8 clock cycles. It falls at the end of the first window that exceeds 8 cycles.
- R7: `pump_hi_cur` equals `cur_hi_req` while the loop is unlocked and is 0 while it is locked.
- R8: `pump_dis_req`=1 drives `pump_off`=1 and holds `pump_up`/`pump_dn` at 0. `drv_dis_req` drives `drv_off`.
- R9: With `test_en`=1, code 000 forces `pump_dn`=1, `pump_up`=0 and `lock_flag`=0. Code 001 forces `pump_up`=1, `pump_dn`=0 and `lock_flag`=1.
- R10: `port_on[3:0]` (bit 3 = P7, bit 0 = P4, 1 = driver on) follows `port_req` in normal operation and in test codes 000, 001, 010 and 011.
- R11: Test code 10x drives P7 with the divider output divided by two. Test code 11x drives P7 with the divider output waveform and P6 with the comparison waveform. The remaining port bits still follow `port_req`.
- R12: While `rst` is high, `pump_up`, `pump_dn` and `lock_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_tick | input | 1 | One pulse per prescaled oscillator cycle |
| div_ratio | input | 15 | Programmable divide ratio N |
| cur_hi_req | input | 1 | Request for high pump current |
| test_en | input | 1 | Test-mode enable |
| pump_dis_req | input | 1 | Charge pump disable request |
| test_sel | input | 3 | Test code; bit 0 also picks the reference ratio |
| drv_dis_req | input | 1 | Drive-amplifier disable request |
| port_req | input | 4 | Requested port driver states, bit 3 = P7 |
| pump_up | output | 1 | Pump sink (frequency up) request |
| pump_dn | output | 1 | Pump source (frequency down) request |
| pump_hi_cur | output | 1 | High pump current select |
| pump_off | output | 1 | Charge pump disable |
| drv_off | output | 1 | Drive-amplifier disable |
| lock_flag | output | 1 | Lock indication |
| port_on | output | 4 | Open-drain driver enables, bit 3 = P7 |

## Verification
The hardest state to reach is a clean lock. It needs the comparison strobe and the divided-oscillator strobe to stay within a few cycles of each other for several windows. The bench reaches it by feeding `osc_tick` on every cycle, with N equal to the reference ratio, from the same reset release, so both counters hit terminal on the same edge. From that locked state it then changes N to show that lock drops, or that the forced test codes override it. Ratio retention and reload timing are checked by timing port waveforms across a mode or ratio change.

// File: rtl/synth_core_pkg.sv
package synth_core_pkg;

    typedef enum logic [2:0] {
        MODE_NORMAL,
        MODE_FORCE_DN,
        MODE_FORCE_UP,
        MODE_PORTS,
        MODE_PD_HALF,
        MODE_PD_FULL
    } tmode_e;

    typedef struct packed {
        logic       cur_hi;
        logic       tmode_en;
        logic       pump_dis;
        logic [2:0] tsel;
        logic       drv_dis;
    } ctl_t;

    typedef struct packed {
        logic up;
        logic dn;
        logic flag;
    } pump_t;

    function automatic tmode_e decode_mode(input ctl_t c);
        tmode_e m;
        if (!c.tmode_en) begin
            m = MODE_NORMAL;
        end else begin
            casez (c.tsel)
                3'b000:  m = MODE_FORCE_DN;
                3'b001:  m = MODE_FORCE_UP;
                3'b01?:  m = MODE_PORTS;
                3'b10?:  m = MODE_PD_HALF;
                default: m = MODE_PD_FULL;
            endcase
        end
        return m;
    endfunction

endpackage

// File: rtl/synth_refdiv.sv
module synth_refdiv #(
    parameter int RATIO_LO = 512,
    parameter int RATIO_HI = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic tmode_en,
    input  logic sel_lo,
    output logic ref_pulse,
    output logic fcomp_wave
);
    localparam int CW = $clog2(RATIO_HI) + 1;

    logic          sel_q;
    logic          sel_next;
    logic [CW-1:0] cnt;
    logic [CW-1:0] ratio_act;
    logic [CW-1:0] ratio_next;

    // the ratio choice is frozen while a test mode is active
    assign sel_next   = tmode_en ? sel_q : sel_lo;
    assign ratio_next = sel_next ? CW'(RATIO_LO) : CW'(RATIO_HI);
    assign ref_pulse  = (cnt == '0);
    assign fcomp_wave = (cnt >= (ratio_act >> 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q     <= 1'b0;
            cnt       <= '0;
            ratio_act <= CW'(RATIO_HI);
        end else begin
            sel_q <= sel_next;
            if (cnt == '0) begin
                ratio_act <= ratio_next;
                cnt       <= ratio_next - CW'(1);
            end else begin
                cnt <= cnt - CW'(1);
            end
        end
    end

    a_r2_ratio_held: assert property (@(posedge clk) disable iff (rst)
        tmode_en |=> (sel_q == $past(sel_q)));

endmodule

// File: rtl/synth_progdiv.sv
module synth_progdiv #(
    parameter int NW = 15
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          osc_tick,
    input  logic [NW-1:0] ratio_n,
    output logic          div_pulse,
    output logic          fpd_wave,
    output logic          fpd_half
);
    logic [NW-1:0] cnt;
    logic [NW-1:0] n_act;

    assign div_pulse = osc_tick && (cnt == '0);
    assign fpd_wave  = (cnt >= (n_act >> 1));

    // new ratio is only sampled at terminal count
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            n_act    <= '0;
            fpd_half <= 1'b0;
        end else if (osc_tick) begin
            if (cnt == '0) begin
                n_act    <= ratio_n;
                cnt      <= (ratio_n == '0) ? '0 : ratio_n - NW'(1);
                fpd_half <= ~fpd_half;
            end else begin
                cnt <= cnt - NW'(1);
            end
        end
    end

    a_r3_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !osc_tick |=> $stable(cnt));

    a_r4_ratio_stable_midperiod: assert property (@(posedge clk) disable iff (rst)
        (cnt != '0) |=> $stable(n_act));

endmodule

// File: rtl/synth_pfd_lock.sv
module synth_pfd_lock #(
    parameter int LOCK_CYC = 4,
    parameter int LOCK_THR = 8,
    parameter int WW       = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_pulse,
    input  logic div_pulse,
    output logic up_q,
    output logic dn_q,
    output logic lock_q
);
    localparam int GW = $clog2(LOCK_CYC + 1);

    logic          up_n;
    logic          dn_n;
    logic [WW-1:0] width;
    logic [GW-1:0] good;
    logic          win_bad;

    always_comb begin
        up_n = up_q | ref_pulse;
        dn_n = dn_q | div_pulse;
        if (up_n && dn_n) begin
            up_n = 1'b0;
            dn_n = 1'b0;
        end
    end

    assign win_bad = (width > WW'(LOCK_THR));

    always_ff @(posedge clk) begin
        if (rst) begin
            up_q   <= 1'b0;
            dn_q   <= 1'b0;
            width  <= '0;
            good   <= '0;
            lock_q <= 1'b0;
        end else begin
            up_q <= up_n;
            dn_q <= dn_n;
            if (ref_pulse) begin
                width <= '0;
                if (win_bad) begin
                    good   <= '0;
                    lock_q <= 1'b0;
                end else begin
                    if (good < GW'(LOCK_CYC)) good <= good + 1'b1;
                    if (good >= GW'(LOCK_CYC - 1)) lock_q <= 1'b1;
                end
            end else if ((up_q || dn_q) && (width != '1)) begin
                width <= width + 1'b1;
            end
        end
    end

    a_r5_never_both: assert property (@(posedge clk) disable iff (rst)
        !(up_q && dn_q));

    a_r6_drop_on_wide: assert property (@(posedge clk) disable iff (rst)
        (ref_pulse && win_bad) |=> !lock_q);

endmodule

// File: rtl/synth_loop_core.sv
module synth_loop_core
    import synth_core_pkg::*;
#(
    parameter int NW       = 15,
    parameter int RATIO_LO = 512,
    parameter int RATIO_HI = 1024,
    parameter int LOCK_CYC = 4,
    parameter int LOCK_THR = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          osc_tick,
    input  logic [NW-1:0] div_ratio,
    input  logic          cur_hi_req,
    input  logic          test_en,
    input  logic          pump_dis_req,
    input  logic [2:0]    test_sel,
    input  logic          drv_dis_req,
    input  logic [3:0]    port_req,
    output logic          pump_up,
    output logic          pump_dn,
    output logic          pump_hi_cur,
    output logic          pump_off,
    output logic          drv_off,
    output logic          lock_flag,
    output logic [3:0]    port_on
);
    localparam int WW = $clog2(RATIO_HI) + 2;

    ctl_t   ctl;
    tmode_e mode;
    pump_t  pm;
    logic   ref_pulse, fcomp_wave;
    logic   div_pulse, fpd_wave, fpd_half;
    logic   up_q, dn_q, lock_q;

    always_comb begin
        ctl.cur_hi   = cur_hi_req;
        ctl.tmode_en = test_en;
        ctl.pump_dis = pump_dis_req;
        ctl.tsel     = test_sel;
        ctl.drv_dis  = drv_dis_req;
    end

    synth_refdiv #(.RATIO_LO(RATIO_LO), .RATIO_HI(RATIO_HI)) u_ref (
        .clk        (clk),
        .rst        (rst),
        .tmode_en   (ctl.tmode_en),
        .sel_lo     (ctl.tsel[0]),
        .ref_pulse  (ref_pulse),
        .fcomp_wave (fcomp_wave)
    );

    synth_progdiv #(.NW(NW)) u_div (
        .clk       (clk),
        .rst       (rst),
        .osc_tick  (osc_tick),
        .ratio_n   (div_ratio),
        .div_pulse (div_pulse),
        .fpd_wave  (fpd_wave),
        .fpd_half  (fpd_half)
    );

    synth_pfd_lock #(.LOCK_CYC(LOCK_CYC), .LOCK_THR(LOCK_THR), .WW(WW)) u_pfd (
        .clk       (clk),
        .rst       (rst),
        .ref_pulse (ref_pulse),
        .div_pulse (div_pulse),
        .up_q      (up_q),
        .dn_q      (dn_q),
        .lock_q    (lock_q)
    );

    always_comb begin
        mode    = decode_mode(ctl);
        pm.up   = up_q;
        pm.dn   = dn_q;
        pm.flag = lock_q;
        port_on = port_req;
        case (mode)
            MODE_FORCE_DN: begin
                pm.up   = 1'b0;
                pm.dn   = 1'b1;
                pm.flag = 1'b0;
            end
            MODE_FORCE_UP: begin
                pm.up   = 1'b1;
                pm.dn   = 1'b0;
                pm.flag = 1'b1;
            end
            MODE_PD_HALF: port_on[3] = fpd_half;
            MODE_PD_FULL: begin
                port_on[3] = fpd_wave;
                port_on[2] = fcomp_wave;
            end
            default: ;
        endcase
        if (ctl.pump_dis) begin
            pm.up = 1'b0;
            pm.dn = 1'b0;
        end
    end

    assign pump_up     = pm.up;
    assign pump_dn     = pm.dn;
    assign lock_flag   = pm.flag;
    assign pump_hi_cur = ctl.cur_hi & ~lock_q;
    assign pump_off    = ctl.pump_dis;
    assign drv_off     = ctl.drv_dis;

    a_r7_low_cur_locked: assert property (@(posedge clk) disable iff (rst)
        lock_q |-> !pump_hi_cur);

    a_r8_pump_quiet: assert property (@(posedge clk) disable iff (rst)
        pump_dis_req |-> (!pump_up && !pump_dn));

    a_r9_force_dn: assert property (@(posedge clk) disable iff (rst)
        (test_en && test_sel == 3'b000 && !pump_dis_req) |-> (pump_dn && !pump_up && !lock_flag));

    a_r12_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> (!up_q && !dn_q && !lock_q));

endmodule

// File: tb/synth_loop_core_test.sv
`timescale 1ns/1ps
module synth_loop_core_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        osc_tick = 1'b1;
    logic [14:0] div_ratio = 15'd512;
    logic        cur_hi_req = 1'b0;
    logic        test_en = 1'b0;
    logic        pump_dis_req = 1'b0;
    logic [2:0]  test_sel = 3'b001;
    logic        drv_dis_req = 1'b0;
    logic [3:0]  port_req = 4'b0000;
    logic        pump_up, pump_dn, pump_hi_cur, pump_off, drv_off, lock_flag;
    logic [3:0]  port_on;
    logic        gap_mode = 1'b0;

    int n_checks = 0;
    int n_fails  = 0;

    always #2.5 clk = ~clk;

    synth_loop_core uut (
        .clk(clk), .rst(rst), .osc_tick(osc_tick), .div_ratio(div_ratio),
        .cur_hi_req(cur_hi_req), .test_en(test_en), .pump_dis_req(pump_dis_req),
        .test_sel(test_sel), .drv_dis_req(drv_dis_req), .port_req(port_req),
        .pump_up(pump_up), .pump_dn(pump_dn), .pump_hi_cur(pump_hi_cur),
        .pump_off(pump_off), .drv_off(drv_off), .lock_flag(lock_flag),
        .port_on(port_on)
    );

    // prescaled oscillator: every cycle, or every other cycle in gap mode
    always @(negedge clk) begin
        if (gap_mode) osc_tick <= ~osc_tick;
        else          osc_tick <= 1'b1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        wait_cyc(3);
        rst = 1'b0;
    endtask

    task automatic count_rises(input int bitn, input int cycles, output int rises);
        logic prev;
        rises = 0;
        prev  = port_on[bitn];
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (!prev && port_on[bitn]) rises++;
            prev = port_on[bitn];
        end
    endtask

    task automatic count_pump(input int cycles, output int ups, output int dns);
        ups = 0;
        dns = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (pump_up) ups++;
            if (pump_dn) dns++;
        end
    endtask

    task automatic wait_rise(output int gap);
        logic prev;
        gap  = 0;
        prev = port_on[3];
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            gap++;
            if (!prev && port_on[3]) break;
            prev = port_on[3];
        end
    endtask

    task automatic t_reset();
        cur_hi_req = 1'b1;
        port_req   = 4'b1001;
        @(negedge clk);
        rst = 1'b1;
        wait_cyc(2);
        check(!pump_up && !pump_dn, "R12 pumps idle in reset", {pump_up, pump_dn}, 0);
        check(!lock_flag, "R12 lock low in reset", lock_flag, 0);
        check(port_on == 4'b1001, "R10 ports follow request", port_on, 9);
        rst = 1'b0;
    endtask

    task automatic t_lock();
        int ups, dns;
        test_en = 1'b0; test_sel = 3'b001; div_ratio = 15'd512; cur_hi_req = 1'b1;
        do_reset();
        wait_cyc(600);
        check(!lock_flag, "R6 no lock before 4 windows", lock_flag, 0);
        check(pump_hi_cur, "R7 high current while unlocked", pump_hi_cur, 1);
        wait_cyc(1600);
        check(lock_flag, "R6 lock after aligned windows", lock_flag, 1);
        check(!pump_hi_cur, "R7 low current while locked", pump_hi_cur, 0);
        count_pump(1000, ups, dns);
        check(ups == 0 && dns == 0, "R5 no pump activity when aligned", ups + dns, 0);
        div_ratio = 15'd500;
        wait_cyc(1200);
        check(!lock_flag, "R6 lock lost on wide window", lock_flag, 0);
        check(pump_hi_cur, "R7 high current restored", pump_hi_cur, 1);
    endtask

    task automatic t_lag_lead();
        int ups, dns;
        test_en = 1'b0; test_sel = 3'b001; div_ratio = 15'd520;
        do_reset();
        count_pump(3000, ups, dns);
        check(ups > 0, "R5 up when divider lags", ups, 1);
        check(dns == 0, "R5 no down when divider lags", dns, 0);
        div_ratio = 15'd500;
        do_reset();
        count_pump(3000, ups, dns);
        check(dns > 0, "R5 down when divider leads", dns, 1);
        check(ups == 0, "R5 no up when divider leads", ups, 0);
        check(!lock_flag, "R6 no lock with ratio mismatch", lock_flag, 0);
    endtask

    task automatic t_ref_ratio();
        int r;
        test_en = 1'b0; test_sel = 3'b001; div_ratio = 15'd256; port_req = 4'b0000;
        do_reset();
        wait_cyc(100);
        test_en = 1'b1; test_sel = 3'b110;
        wait_cyc(10);
        count_rises(2, 4096, r);
        check(r >= 7 && r <= 9, "R1 ratio 512 gives 8 periods", r, 8);
        check(r >= 7 && r <= 9, "R2 ratio kept after test code with bit0=0", r, 8);
        test_en = 1'b0; test_sel = 3'b000;
        wait_cyc(1200);
        test_en = 1'b1; test_sel = 3'b111;
        wait_cyc(10);
        count_rises(2, 4096, r);
        check(r >= 3 && r <= 5, "R2 ratio 1024 kept after test code with bit0=1", r, 4);
        test_en = 1'b0;
    endtask

    task automatic t_fpd();
        int r;
        test_en = 1'b0; test_sel = 3'b001; div_ratio = 15'd256; port_req = 4'b0110;
        do_reset();
        test_en = 1'b1; test_sel = 3'b110;
        wait_cyc(600);
        count_rises(3, 4096, r);
        check(r >= 15 && r <= 17, "R11 P7 carries divider output", r, 16);
        test_sel = 3'b100;
        wait_cyc(600);
        count_rises(3, 4096, r);
        check(r >= 7 && r <= 9, "R11 P7 carries divider output halved", r, 8);
        check(port_on[2:0] == 3'b110, "R11 other ports follow request", port_on[2:0], 6);
        test_sel = 3'b110; div_ratio = 15'd128; gap_mode = 1'b1;
        wait_cyc(600);
        count_rises(3, 4096, r);
        check(r >= 15 && r <= 17, "R3 gapped ticks stretch divider period", r, 16);
        gap_mode = 1'b0;
        test_en = 1'b0;
    endtask

    task automatic t_reload();
        int g;
        test_en = 1'b0; test_sel = 3'b001; div_ratio = 15'd300;
        do_reset();
        test_en = 1'b1; test_sel = 3'b110;
        wait_rise(g);
        wait_rise(g);
        wait_cyc(5);
        div_ratio = 15'd100;
        wait_rise(g);
        check(g == 295, "R4 current period keeps old ratio", g, 295);
        wait_rise(g);
        check(g == 100, "R4 next period uses new ratio", g, 100);
        test_en = 1'b0;
    endtask

    task automatic t_pump_ctl();
        int ups, dns;
        test_en = 1'b0; test_sel = 3'b001; div_ratio = 15'd520;
        pump_dis_req = 1'b1; drv_dis_req = 1'b1;
        do_reset();
        count_pump(2000, ups, dns);
        check(ups == 0 && dns == 0, "R8 pump silent when disabled", ups + dns, 0);
        check(pump_off && drv_off, "R8 disable outputs set", {pump_off, drv_off}, 3);
        pump_dis_req = 1'b0; drv_dis_req = 1'b0;
        wait_cyc(2);
        check(!pump_off && !drv_off, "R8 disable outputs clear", {pump_off, drv_off}, 0);
    endtask

    task automatic t_forced();
        test_en = 1'b0; test_sel = 3'b001; div_ratio = 15'd512;
        do_reset();
        wait_cyc(2200);
        test_en = 1'b1; test_sel = 3'b000;
        wait_cyc(2);
        check(pump_dn && !pump_up, "R9 forced down", {pump_up, pump_dn}, 1);
        check(!lock_flag, "R9 lock flag forced low", lock_flag, 0);
        test_en = 1'b0; test_sel = 3'b001; div_ratio = 15'd500;
        do_reset();
        wait_cyc(800);
        test_en = 1'b1;
        wait_cyc(2);
        check(pump_up && !pump_dn, "R9 forced up", {pump_up, pump_dn}, 2);
        check(lock_flag, "R9 lock flag forced high", lock_flag, 1);
        test_en = 1'b0;
    endtask

    task automatic t_ports();
        test_en = 1'b0; port_req = 4'b1010;
        wait_cyc(2);
        check(port_on == 4'b1010, "R10 normal mode ports", port_on, 10);
        test_en = 1'b1; test_sel = 3'b010; port_req = 4'b0101;
        wait_cyc(2);
        check(port_on == 4'b0101, "R10 port test code", port_on, 5);
        test_sel = 3'b000; port_req = 4'b1100;
        wait_cyc(2);
        check(port_on == 4'b1100, "R10 forced pump code keeps ports", port_on, 12);
        test_en = 1'b0;
    endtask

    initial begin
        #(5.0 * 190000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
        $finish;
    end

    initial begin
        t_reset();
        t_lock();
        t_lag_lead();
        t_ref_ratio();
        t_fpd();
        t_reload();
        t_pump_ctl();
        t_forced();
        t_ports();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
        $finish;
    end

endmodule